// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block decides when a DRAM row refresh is due and which row it targets. An interval timer derived from the clock frequency and the retention period produces refresh credits. A pending-refresh counter (the debt) holds credits that the memory controller has not yet served. A row pointer names the next row to refresh. The controller sees a level request and answers with a grant. Each granted request consumes one credit and moves the pointer to the following row.

Three credit sources are selectable. In distributed mode one credit arrives every interval, where the interval is the retention period divided by the row count. In burst mode a whole sweep of credits, one per row, arrives once per period, so all rows are refreshed back to back. In external mode a system event input, such as a display blanking pulse, adds a fixed portion of rows on each cycle it is high.

The controller may postpone refreshes while it is busy, but only by a bounded amount. Once the debt reaches its limit, an urgent flag tells the controller to place the refresh ahead of normal traffic. Command sequencing to the DRAM is left to the controller.

Top module: `rfsh_sched`

## Requirements
- R1: After a synchronous reset `req_o` and `urgent_o` are 0, `row_o` is 0, `debt_o` is 0, and the interval timer restarts from zero.
- R2: With `mode_i` = 2'b00 (distributed), `debt_o` gains one credit at the end of every INTERVAL cycles. INTERVAL is CLK_MHZ*RETENTION_US/ROWS, rounded down. The first credit becomes visible INTERVAL cycles after reset is released.
- R3: With `mode_i` = 2'b01 (burst), `debt_o` gains ROWS credits at the end of every ROWS*INTERVAL cycles.
- R4: With `mode_i` = 2'b10 (external), the timer is held at zero and every clock in which `ext_tick_i` is 1 adds PORTION credits. In every other mode `ext_tick_i` has no effect.
- R5: `req_o` is 1 exactly when `debt_o` is nonzero. It stays 1 until enough grants have been given.
- R6: A cycle with `grant_i` and `req_o` both 1 lowers the debt by one and advances `row_o` by one. If the same cycle also brings new credits, they are added in that cycle. A `grant_i` while `req_o` is 0 changes nothing.
- R7: `row_o` wraps from ROWS-1 to 0 on a grant.
- R8: `debt_o` saturates at MAX_DEBT in the distributed modes and at ROWS+MAX_DEBT in burst and external modes. A larger debt is clipped to the distributed limit on the first clock spent in a distributed mode.
- R9: `urgent_o` is 1 exactly when `debt_o` is at least MAX_DEBT.
- R10: `mode_i` = 2'b11 behaves exactly as distributed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Credit source: 00/11 distributed, 01 burst, 10 external |
| ext_tick_i | input | 1 | External refresh event, used only in external mode |
| grant_i | input | 1 | Controller accepts the current refresh |
| req_o | output | 1 | A refresh is pending |
| urgent_o | output | 1 | Debt at its limit; refresh outranks normal traffic |
| row_o | output | $clog2(ROWS) | Row to refresh on the next grant |
| debt_o | output | $clog2(2*ROWS+MAX_DEBT+1) | Number of pending refreshes |

## Verification
A wrong timer count shows up at the ports as a credit that arrives one or more cycles early or late on `debt_o`. That difference is caught on the first interval or sweep boundary after the fault. A corrupted debt shows on the next cycle as a mismatch in `debt_o`, `req_o` or `urgent_o`. A wrong row pointer appears in `row_o` right away and is caught at the latest when the next wrap should occur. The bench compares all four outputs every cycle against a reference model. That model is built from the interval, sweep, portion and saturation rules, under random grant patterns in each mode.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        MODE_DIST     = 2'b00,
        MODE_BURST    = 2'b01,
        MODE_EXT      = 2'b10,
        MODE_DIST_ALT = 2'b11
    } rfsh_mode_e;

    function automatic int cycles_per_row(int clk_mhz, int retention_us, int rows);
        return (clk_mhz * retention_us) / rows;
    endfunction

    function automatic int debt_width(int rows, int max_debt);
        return $clog2(2 * rows + max_debt + 1);
    endfunction

    function automatic logic wide_cap(rfsh_mode_e m);
        return (m == MODE_BURST) || (m == MODE_EXT);
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer
    import rfsh_pkg::*;
#(
    parameter int INTERVAL = 31,
    parameter int ROWS     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  rfsh_mode_e mode,
    output logic       tick
);
    localparam int SWEEP = INTERVAL * ROWS;
    localparam int CNT_W = $clog2(SWEEP + 1);
    localparam logic [CNT_W-1:0] LAST_ROW_CYC   = CNT_W'(INTERVAL - 1);
    localparam logic [CNT_W-1:0] LAST_SWEEP_CYC = CNT_W'(SWEEP - 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        unique case (mode)
            MODE_EXT:   tick = 1'b0;
            MODE_BURST: tick = (cnt >= LAST_SWEEP_CYC);
            default:    tick = (cnt >= LAST_ROW_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || mode == MODE_EXT || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt
    import rfsh_pkg::*;
#(
    parameter int ROWS     = 16,
    parameter int MAX_DEBT = 8,
    parameter int PORTION  = 4,
    parameter int W        = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  rfsh_mode_e   mode,
    input  logic         tick,
    input  logic         ext_tick,
    input  logic         take,
    output logic [W-1:0] debt
);
    localparam logic [W:0] CAP_NARROW = (W+1)'(MAX_DEBT);
    localparam logic [W:0] CAP_WIDE   = (W+1)'(ROWS + MAX_DEBT);
    localparam logic [W:0] ADD_ONE    = (W+1)'(1);
    localparam logic [W:0] ADD_SWEEP  = (W+1)'(ROWS);
    localparam logic [W:0] ADD_PART   = (W+1)'(PORTION);

    logic [W:0] add;
    logic [W:0] sum;
    logic [W:0] cap;

    always_comb begin
        if (tick) begin
            add = (mode == MODE_BURST) ? ADD_SWEEP : ADD_ONE;
        end else if (mode == MODE_EXT && ext_tick) begin
            add = ADD_PART;
        end else begin
            add = '0;
        end
        cap = wide_cap(mode) ? CAP_WIDE : CAP_NARROW;
        sum = {1'b0, debt} + add - {{W{1'b0}}, take};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            debt <= '0;
        end else if (sum > cap) begin
            debt <= cap[W-1:0];
        end else begin
            debt <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/rfsh_row.sv
module rfsh_row #(
    parameter int ROWS = 16,
    parameter int RW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [RW-1:0] row
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (step) begin
            row <= (row == LAST) ? '0 : row + 1'b1;
        end
    end

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int ROWS         = 16,
    parameter int CLK_MHZ      = 250,
    parameter int RETENTION_US = 2,
    parameter int MAX_DEBT     = 8,
    parameter int PORTION      = 4
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [1:0]                                     mode_i,
    input  logic                                           ext_tick_i,
    input  logic                                           grant_i,
    output logic                                           req_o,
    output logic                                           urgent_o,
    output logic [$clog2(ROWS)-1:0]                        row_o,
    output logic [$clog2(2*ROWS+MAX_DEBT+1)-1:0]           debt_o
);
    localparam int INTERVAL = cycles_per_row(CLK_MHZ, RETENTION_US, ROWS);
    localparam int RW       = $clog2(ROWS);
    localparam int DW       = debt_width(ROWS, MAX_DEBT);
    localparam logic [DW-1:0] URGENT_AT = DW'(MAX_DEBT);

    rfsh_mode_e mode;
    logic       tick;
    logic       take;

    assign mode     = rfsh_mode_e'(mode_i);
    assign req_o    = (debt_o != '0);
    assign take     = req_o && grant_i;
    assign urgent_o = (debt_o >= URGENT_AT);

    rfsh_timer #(.INTERVAL(INTERVAL), .ROWS(ROWS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .tick (tick)
    );

    rfsh_debt #(.ROWS(ROWS), .MAX_DEBT(MAX_DEBT), .PORTION(PORTION), .W(DW)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .tick     (tick),
        .ext_tick (ext_tick_i),
        .take     (take),
        .debt     (debt_o)
    );

    rfsh_row #(.ROWS(ROWS), .RW(RW)) u_row (
        .clk  (clk),
        .rst  (rst),
        .step (take),
        .row  (row_o)
    );

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int ROWS     = 16,
    parameter int MAX_DEBT = 8,
    parameter int RW       = 4,
    parameter int DW       = 6
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_i,
    input logic          grant_i,
    input logic          req_o,
    input logic          urgent_o,
    input logic [RW-1:0] row_o,
    input logic [DW-1:0] debt_o
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);
    localparam logic [DW-1:0] LIM  = DW'(MAX_DEBT);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (debt_o == '0 && row_o == '0 && !req_o)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_o && !grant_i) |=> req_o); // R5

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (req_o && grant_i) |=> (row_o == (($past(row_o) == LAST) ? '0 : $past(row_o) + 1'b1))); // R7

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req_o && grant_i) |=> $stable(row_o)); // R6

    AST_DIST_CAP: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00 || mode_i == 2'b11) |=> (debt_o <= LIM)); // R8

    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (rst)
        urgent_o |-> req_o); // R9

endmodule

bind rfsh_sched rfsh_sched_chk #(
    .ROWS(ROWS), .MAX_DEBT(MAX_DEBT), .RW($clog2(ROWS)), .DW($clog2(2*ROWS+MAX_DEBT+1))
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .grant_i  (grant_i),
    .req_o    (req_o),
    .urgent_o (urgent_o),
    .row_o    (row_o),
    .debt_o   (debt_o)
);

// File: tb/tb_rfsh_sched.sv
module tb_rfsh_sched;
    localparam int ROWS     = 16;
    localparam int CLK_MHZ  = 250;
    localparam int RET_US   = 2;
    localparam int MAXD     = 8;
    localparam int PORTION  = 4;
    localparam int INTERVAL = (CLK_MHZ * RET_US) / ROWS;
    localparam int RW       = $clog2(ROWS);
    localparam int DW       = $clog2(2*ROWS+MAXD+1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_i = 2'b00;
    logic          ext_tick_i = 1'b0;
    logic          grant_i = 1'b0;
    logic          req_o;
    logic          urgent_o;
    logic [RW-1:0] row_o;
    logic [DW-1:0] debt_o;

    int checks = 0;
    int errors = 0;
    int m_cnt, m_debt, m_row;
    string debt_tag = "R2";

    always #2 clk = ~clk;

    rfsh_sched #(.ROWS(ROWS), .CLK_MHZ(CLK_MHZ), .RETENTION_US(RET_US),
                 .MAX_DEBT(MAXD), .PORTION(PORTION)) dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .ext_tick_i(ext_tick_i),
        .grant_i(grant_i), .req_o(req_o), .urgent_o(urgent_o),
        .row_o(row_o), .debt_o(debt_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference step: applies the rules of R2..R10 to the model state.
    task automatic model_step(input int mode, input bit gnt, input bit ext);
        bit tick;
        int add, cap, sum;
        int lim;
        lim = (mode == 1) ? INTERVAL * ROWS : INTERVAL;
        tick = (mode != 2) && (m_cnt >= lim - 1);
        add = tick ? ((mode == 1) ? ROWS : 1) : ((mode == 2 && ext) ? PORTION : 0);
        cap = (mode == 1 || mode == 2) ? ROWS + MAXD : MAXD;
        sum = m_debt + add;
        if (gnt && m_debt != 0) begin
            sum--;
            m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
        end
        m_debt = (sum > cap) ? cap : sum;
        m_cnt = (mode == 2 || tick) ? 0 : m_cnt + 1;
    endtask

    task automatic compare_all();
        check(debt_tag, "debt", int'(debt_o), m_debt);
        check("R5", "req", int'(req_o), int'(m_debt != 0));
        check("R9", "urgent", int'(urgent_o), int'(m_debt >= MAXD));
        check("R7", "row", int'(row_o), m_row);
    endtask

    task automatic step(input bit gnt, input bit ext);
        grant_i = gnt;
        ext_tick_i = ext;
        model_step(int'(mode_i), gnt, ext);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        grant_i = 1'b0;
        ext_tick_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_debt = 0; m_row = 0;
    endtask

    task automatic run_phase(input logic [1:0] m, input string tag, input int n, input int gnt_mod, input int ext_mod);
        mode_i = m;
        debt_tag = tag;
        for (int i = 0; i < n; i++) begin
            step(gnt_mod != 0 && ($urandom % gnt_mod) == 0, ($urandom % ext_mod) == 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240517));
        @(negedge clk);
        do_reset();
        check("R1", "reset debt", int'(debt_o), 0);
        check("R1", "reset row", int'(row_o), 0);
        check("R1", "reset req", int'(req_o), 0);
        check("R1", "reset urgent", int'(urgent_o), 0);

        // R6: grant with no pending request must not move the pointer.
        mode_i = 2'b00;
        for (int i = 0; i < INTERVAL - 2; i++) step(1'b1, 1'b0);
        check("R6", "row after idle grants", int'(row_o), 0);
        check("R6", "debt after idle grants", int'(debt_o), 0);

        // R2: first credit exactly INTERVAL cycles after reset release.
        step(1'b0, 1'b0);
        check("R2", "debt one cycle early", int'(debt_o), 0);
        step(1'b0, 1'b0);
        check("R2", "first credit", int'(debt_o), 1);

        // R8/R9: no grants, ext pulses ignored in distributed mode (R4).
        run_phase(2'b00, "R4", 12 * INTERVAL, 0, 3);
        check("R8", "distributed cap", int'(debt_o), MAXD);
        check("R9", "urgent at cap", int'(urgent_o), 1);

        // R3 and wide cap R8: burst sweep without grants.
        run_phase(2'b01, "R3", INTERVAL * ROWS + 4, 0, 2);
        check("R8", "burst cap", int'(debt_o), ROWS + MAXD);

        // R8: clip back to the narrow cap in distributed mode.
        mode_i = 2'b00;
        debt_tag = "R8";
        step(1'b0, 1'b0);
        check("R8", "clip on return", int'(debt_o), MAXD);

        run_phase(2'b00, "R2", 3000, 24, 4);
        run_phase(2'b01, "R3", 4000, 2, 4);
        run_phase(2'b10, "R4", 1500, 2, 12);
        run_phase(2'b11, "R10", 1500, 20, 3);
        run_phase(2'b01, "R3", 2000, 1, 4);

        do_reset();
        @(negedge clk);
        check("R1", "second reset debt", int'(debt_o), 0);
        check("R1", "second reset row", int'(row_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule